// File: doc/BRIEF.md
# Flash line buffer and prefetch controller

This block sits between a read-only system bus and a slow flash array. It keeps four 256-bit line buffers. A bus read whose line is already buffered is answered from the buffer without touching the array. A read that misses fetches the whole line from the array, returns the addressed word and keeps the line for later reads. After a miss from a bus master that is allowed to prefetch, the block fetches the next sequential line in the background. A new demand read that arrives before that fetch starts cancels it.

The buffers are cleared in four cases: when buffering is switched on, when it is switched off, when a program or erase operation starts, and when software asks for an explicit clear. A programmable count of extra wait states emulates a slower memory. When the count is non-zero, every read goes to the array, no prefetch starts, and the bus termination is delayed by exactly that many cycles.

Top module: `flash_linebuf_ctrl`

## Requirements
- R1: When buffering is on, the wait-state count is zero and the requested line is held in a valid buffer, `req_ready` rises one cycle after the request is accepted. It carries the addressed word and no array fetch is made.
- R2: A read that is not answered from a buffer fetches its line from the array. `req_addr` is a word address: bits [2:0] select the 32-bit word and the upper bits give the line number. Word w of a line is `arr_data[32w+31:32w]`. With no extra wait states, `req_ready` rises in the cycle after `arr_ack`, and the line is stored when buffering is on.
- R3: There are four buffers. A fill uses an invalid buffer if one exists. Otherwise it replaces the least recently used buffer, where both a hit and a fill count as a use.
- R4: While `buf_en` is low, no read is answered from a buffer and no line is stored.
- R5: Any change of `buf_en`, either rising or falling, clears every buffer.
- R6: A one-cycle `pe_start` pulse clears every buffer.
- R7: A one-cycle `inv_req` pulse clears every buffer.
- R8: If a clear occurs in the same cycle as a line's arrival, or while its fetch is outstanding, that line is not stored. The demand read is still answered with correct data.
- R9: After a demand miss from master m with `pf_mask[m]` set, the next line (line number plus one, wrapping) is fetched and stored while the bus is idle. With `pf_mask[m]` clear, no prefetch is made.
- R10: A pending prefetch is dropped if a demand request is accepted before the prefetch has been issued.
- R11: When `ews_cnt` is k > 0, `req_ready` rises k cycles later than it would with `ews_cnt` at zero.
- R12: While `ews_cnt` is non-zero, buffered lines give no hits, so every read fetches from the array, and no prefetch is started.
- R13: `req_ready` is high for exactly one cycle per access, and `arr_req` stays high with a stable `arr_line` until `arr_ack`. After reset, both are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Bus read request, held until `req_ready` |
| req_addr | input | ADDR_W | Word address of the read |
| req_mid | input | clog2(NMST) | ID of the requesting master |
| req_ready | output | 1 | One-cycle termination with the read data |
| rsp_data | output | 32 | Read data, valid while `req_ready` is high |
| buf_en | input | 1 | Buffering on; each change clears the buffers |
| pe_start | input | 1 | Pulse at the start of a program or erase operation |
| inv_req | input | 1 | Explicit clear pulse for all buffers |
| pf_mask | input | NMST | Per-master prefetch permission, one bit for each master ID |
| ews_cnt | input | EWS_W | Count of extra wait states to emulate |
| arr_req | output | 1 | Array line fetch request |
| arr_line | output | ADDR_W-3 | Line number being fetched |
| arr_ack | input | 1 | One-cycle array completion, with the line on `arr_data` |
| arr_data | input | 256 | Line data from the array |

## Verification
The properties assume that masters behave as follows. A master holds `req_valid`, `req_addr` and `req_mid` steady from the request until `req_ready`, and drops `req_valid` in the cycle `req_ready` is seen. The array raises `arr_ack` for a single cycle and only while `arr_req` is high. `ews_cnt` is not changed while an access is in flight. The bench drives every request through one read task that follows this handshake, and its array model answers after a fixed latency. It changes the wait-state count, the mask and `buf_en` only when the bus is idle, and clear pulses come either from idle cycles or from the array model, timed to the acknowledge.

// File: rtl/flb_pkg.sv
package flb_pkg;
  localparam int WORD_W = 32;
  localparam int LINE_W = 256;
  localparam int WPL    = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WPL);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DFETCH,
    ST_PFETCH,
    ST_EXTRA,
    ST_RESP
  } fsm_t;

  // select one bus word out of a full line
  function automatic logic [WORD_W-1:0] pick_word(input logic [LINE_W-1:0] line,
                                                  input logic [WSEL_W-1:0] sel);
    return line[sel*WORD_W +: WORD_W];
  endfunction
endpackage

// File: rtl/flb_tags.sv
module flb_tags #(
  parameter int NBUF = 4,
  parameter int LAW  = 13,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv,
  input  logic [LAW-1:0]   a_line,
  output logic             a_hit,
  output logic [IDX_W-1:0] a_idx,
  input  logic [LAW-1:0]   b_line,
  output logic             b_hit,
  input  logic             fill_we,
  input  logic [LAW-1:0]   fill_line,
  output logic [IDX_W-1:0] victim,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_idx,
  output logic [NBUF-1:0]  valid_o
);
  logic [NBUF-1:0]  valid_q;
  logic [LAW-1:0]   tag_q [NBUF];
  logic [IDX_W-1:0] age_q [NBUF];
  logic [NBUF-1:0]  a_match;
  logic [NBUF-1:0]  b_match;

  for (genvar g = 0; g < NBUF; g++) begin : g_cmp
    assign a_match[g] = valid_q[g] && (tag_q[g] == a_line);
    assign b_match[g] = valid_q[g] && (tag_q[g] == b_line);
  end

  assign a_hit   = |a_match;
  assign b_hit   = |b_match;
  assign valid_o = valid_q;

  always_comb begin
    a_idx = '0;
    for (int i = NBUF - 1; i >= 0; i--) begin
      if (a_match[i]) a_idx = IDX_W'(i);
    end
  end

  // invalid entry first, else the oldest
  always_comb begin
    logic found;
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (!valid_q[i] && !found) begin
        victim = IDX_W'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < NBUF; i++) begin
        if (age_q[i] == IDX_W'(NBUF - 1)) victim = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < NBUF; i++) begin
        tag_q[i] <= '0;
        age_q[i] <= IDX_W'(i);
      end
    end else begin
      if (inv) begin
        valid_q <= '0;
      end else if (fill_we) begin
        valid_q[victim] <= 1'b1;
        tag_q[victim]   <= fill_line;
      end
      if (touch_en) begin
        for (int i = 0; i < NBUF; i++) begin
          if (IDX_W'(i) == touch_idx)            age_q[i] <= '0;
          else if (age_q[i] < age_q[touch_idx])  age_q[i] <= age_q[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flb_lines.sv
module flb_lines
  import flb_pkg::*;
#(
  parameter int NBUF = 4,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [LINE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  input  logic [WSEL_W-1:0] rsel,
  output logic [WORD_W-1:0] rword
);
  logic [LINE_W-1:0] mem [NBUF];

  for (genvar g = 0; g < NBUF; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (we && (widx == IDX_W'(g))) mem[g] <= wdata;
    end
  end

  assign rword = pick_word(mem[ridx], rsel);
endmodule

// File: rtl/flb_waitgen.sv
module flb_waitgen #(
  parameter int EWS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [EWS_W-1:0] load_val,
  output logic             done
);
  logic [EWS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == EWS_W'(1));
endmodule

// File: rtl/flash_linebuf_ctrl.sv
module flash_linebuf_ctrl
  import flb_pkg::*;
#(
  parameter int NBUF   = 4,
  parameter int ADDR_W = 16,
  parameter int NMST   = 4,
  parameter int EWS_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [$clog2(NMST)-1:0]   req_mid,
  output logic                      req_ready,
  output logic [WORD_W-1:0]         rsp_data,
  input  logic                      buf_en,
  input  logic                      pe_start,
  input  logic                      inv_req,
  input  logic [NMST-1:0]           pf_mask,
  input  logic [EWS_W-1:0]          ews_cnt,
  output logic                      arr_req,
  output logic [ADDR_W-WSEL_W-1:0]  arr_line,
  input  logic                      arr_ack,
  input  logic [LINE_W-1:0]         arr_data
);
  localparam int LAW   = ADDR_W - WSEL_W;
  localparam int IDX_W = $clog2(NBUF);
  localparam int MID_W = $clog2(NMST);

  function automatic logic [LAW-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:WSEL_W];
  endfunction

  function automatic logic [WSEL_W-1:0] sel_of(input logic [ADDR_W-1:0] a);
    return a[WSEL_W-1:0];
  endfunction

  function automatic logic [LAW-1:0] next_line(input logic [LAW-1:0] l);
    return l + 1'b1;
  endfunction

  fsm_t              state_q;
  logic [LAW-1:0]    fetch_line_q;
  logic [WSEL_W-1:0] sel_q;
  logic [MID_W-1:0]  mid_q;
  logic [WORD_W-1:0] rdata_q;
  logic              pf_pend_q;
  logic [LAW-1:0]    pf_line_q;
  logic              kill_q;
  logic              buf_en_q;

  logic [LAW-1:0]    req_line;
  logic [WSEL_W-1:0] req_sel;
  logic              a_hit, b_hit;
  logic [IDX_W-1:0]  a_idx, victim;
  logic [NBUF-1:0]   valid_mask;
  logic [WORD_W-1:0] store_word;

  // named internal events
  logic inv_evt, hits_ok, is_idle, in_fetch, dem_fetch;
  logic hit_accept, miss_accept, pf_issue, fill_we;
  logic wait_load, wait_done, pf_arm, dem_done;

  assign req_line    = line_of(req_addr);
  assign req_sel     = sel_of(req_addr);
  assign inv_evt     = inv_req | pe_start | (buf_en ^ buf_en_q);
  assign hits_ok     = buf_en && (ews_cnt == '0);
  assign is_idle     = (state_q == ST_IDLE);
  assign dem_fetch   = (state_q == ST_DFETCH);
  assign in_fetch    = dem_fetch || (state_q == ST_PFETCH);
  assign hit_accept  = is_idle && req_valid && a_hit && hits_ok;
  assign miss_accept = is_idle && req_valid && !(a_hit && hits_ok);
  assign pf_issue    = is_idle && !req_valid && pf_pend_q && hits_ok && !b_hit && !inv_evt;
  assign fill_we     = in_fetch && arr_ack && buf_en && !inv_evt && !kill_q;
  assign dem_done    = dem_fetch && arr_ack;
  assign wait_load   = dem_done && (ews_cnt != '0);
  assign pf_arm      = dem_done && pf_mask[mid_q] && hits_ok;

  flb_tags #(.NBUF(NBUF), .LAW(LAW)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv       (inv_evt),
    .a_line    (req_line),
    .a_hit     (a_hit),
    .a_idx     (a_idx),
    .b_line    (pf_line_q),
    .b_hit     (b_hit),
    .fill_we   (fill_we),
    .fill_line (fetch_line_q),
    .victim    (victim),
    .touch_en  (hit_accept | fill_we),
    .touch_idx (hit_accept ? a_idx : victim),
    .valid_o   (valid_mask)
  );

  flb_lines #(.NBUF(NBUF)) u_lines (
    .clk   (clk),
    .we    (fill_we),
    .widx  (victim),
    .wdata (arr_data),
    .ridx  (a_idx),
    .rsel  (req_sel),
    .rword (store_word)
  );

  flb_waitgen #(.EWS_W(EWS_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wait_load),
    .load_val (ews_cnt),
    .done     (wait_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      fetch_line_q <= '0;
      sel_q        <= '0;
      mid_q        <= '0;
      rdata_q      <= '0;
      buf_en_q     <= 1'b0;
    end else begin
      buf_en_q <= buf_en;
      case (state_q)
        ST_IDLE: begin
          if (hit_accept) begin
            rdata_q <= store_word;
            state_q <= ST_RESP;
          end else if (miss_accept) begin
            fetch_line_q <= req_line;
            sel_q        <= req_sel;
            mid_q        <= req_mid;
            state_q      <= ST_DFETCH;
          end else if (pf_issue) begin
            fetch_line_q <= pf_line_q;
            state_q      <= ST_PFETCH;
          end
        end
        ST_DFETCH: begin
          if (arr_ack) begin
            rdata_q <= pick_word(arr_data, sel_q);
            state_q <= (ews_cnt != '0) ? ST_EXTRA : ST_RESP;
          end
        end
        ST_PFETCH: if (arr_ack)   state_q <= ST_IDLE;
        ST_EXTRA:  if (wait_done) state_q <= ST_RESP;
        ST_RESP:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  // prefetch bookkeeping: clear conditions win over arming
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_pend_q <= 1'b0;
      pf_line_q <= '0;
    end else if (inv_evt || !hits_ok) begin
      pf_pend_q <= 1'b0;
    end else if (pf_arm) begin
      pf_pend_q <= 1'b1;
      pf_line_q <= next_line(fetch_line_q);
    end else if (is_idle && (req_valid || b_hit || pf_issue)) begin
      pf_pend_q <= 1'b0;
    end
  end

  // a clear during an outstanding fetch spoils its fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      kill_q <= 1'b0;
    else if (miss_accept || pf_issue) kill_q <= 1'b0;
    else if (in_fetch && inv_evt)     kill_q <= 1'b1;
  end

  assign req_ready = (state_q == ST_RESP);
  assign rsp_data  = rdata_q;
  assign arr_req   = in_fetch;
  assign arr_line  = fetch_line_q;
endmodule

// File: rtl/flb_checker.sv
module flb_checker #(
  parameter int EWS_W = 4,
  parameter int NBUF  = 4,
  parameter int LAW   = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             arr_req,
  input logic             arr_ack,
  input logic [LAW-1:0]   arr_line,
  input logic [EWS_W-1:0] ews_cnt,
  input logic             hit_accept,
  input logic             dem_fetch,
  input logic             inv_evt,
  input logic [NBUF-1:0]  valid_mask
);
  a_r13_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  a_r13_arr_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_req && !arr_ack) |=> (arr_req && $stable(arr_line)));

  a_r1_hit_answers_next: assert property (@(posedge clk) disable iff (!rst_n)
    hit_accept |=> (req_ready && !arr_req));

  a_r2_miss_answers_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_fetch && arr_ack && (ews_cnt == '0)) |=> req_ready);

  a_r11_termination_stretched: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_fetch && arr_ack && (ews_cnt != '0)) |=> !req_ready);

  a_r5_clear_empties_all: assert property (@(posedge clk) disable iff (!rst_n)
    inv_evt |=> (valid_mask == '0));
endmodule

bind flash_linebuf_ctrl flb_checker #(.EWS_W(EWS_W), .NBUF(NBUF), .LAW(LAW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .arr_req    (arr_req),
  .arr_ack    (arr_ack),
  .arr_line   (arr_line),
  .ews_cnt    (ews_cnt),
  .hit_accept (hit_accept),
  .dem_fetch  (dem_fetch),
  .inv_evt    (inv_evt),
  .valid_mask (valid_mask)
);

// File: tb/flash_linebuf_ctrl_tb.sv
module flash_linebuf_ctrl_tb;
  import flb_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int NMST       = 4;
  localparam int EWS_W      = 4;
  localparam int NBUF       = 4;
  localparam int LAW        = ADDR_W - WSEL_W;
  localparam int ARR_LAT    = 3;
  localparam int MISS_LAT   = ARR_LAT + 1;
  localparam int NVEC       = 12;

  // {word address, expect hit}
  localparam logic [16:0] VEC [NVEC] = '{
    {16'h0083, 1'b0}, {16'h0100, 1'b0}, {16'h0187, 1'b0}, {16'h0201, 1'b0},
    {16'h0085, 1'b1}, {16'h0282, 1'b0}, {16'h0106, 1'b0}, {16'h0080, 1'b1},
    {16'h0184, 1'b0}, {16'h0203, 1'b0}, {16'h0281, 1'b0}, {16'h0087, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_mid = '0;
  logic              req_ready;
  logic [31:0]       rsp_data;
  logic              buf_en = 1'b1;
  logic              pe_start = 1'b0;
  logic              inv_tb = 1'b0;
  logic              inv_arr = 1'b0;
  logic              inv_req;
  logic [NMST-1:0]   pf_mask = '0;
  logic [EWS_W-1:0]  ews_cnt = '0;
  logic              arr_req;
  logic [LAW-1:0]    arr_line;
  logic              arr_ack = 1'b0;
  logic [LINE_W-1:0] arr_data = '0;

  int checks = 0;
  int errors = 0;
  int fetch_cnt = 0;
  bit inv_at_ack = 1'b0;
  bit pulse_bad = 1'b0;

  assign inv_req = inv_tb | inv_arr;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_linebuf_ctrl #(.NBUF(NBUF), .ADDR_W(ADDR_W), .NMST(NMST), .EWS_W(EWS_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_mid(req_mid), .req_ready(req_ready), .rsp_data(rsp_data),
    .buf_en(buf_en), .pe_start(pe_start), .inv_req(inv_req), .pf_mask(pf_mask),
    .ews_cnt(ews_cnt), .arr_req(arr_req), .arr_line(arr_line),
    .arr_ack(arr_ack), .arr_data(arr_data)
  );

  function automatic logic [31:0] mk_word(input logic [LAW-1:0] l, input int w);
    return 32'h5A00_0000 ^ (32'(l) << 4) ^ 32'(w);
  endfunction

  function automatic logic [LINE_W-1:0] mk_line(input logic [LAW-1:0] l);
    logic [LINE_W-1:0] r;
    for (int w = 0; w < WPL; w++) r[w*WORD_W +: WORD_W] = mk_word(l, w);
    return r;
  endfunction

  // behavioural array with fixed latency
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (arr_ack) begin
        arr_ack = 1'b0;
        inv_arr = 1'b0;
      end else if (arr_req) begin
        cnt++;
        if (cnt == ARR_LAT) begin
          cnt = 0;
          arr_ack = 1'b1;
          arr_data = mk_line(arr_line);
          fetch_cnt++;
          if (inv_at_ack) begin
            inv_arr = 1'b1;
            inv_at_ack = 1'b0;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called and returns at a falling edge
  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [1:0] m,
                         output logic [31:0] d, output int lat);
    req_valid = 1'b1;
    req_addr  = a;
    req_mid   = m;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_ready && lat < 200);
    d = rsp_data;
    req_valid = 1'b0;
    @(negedge clk);
    if (req_ready) pulse_bad = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_bufs();
    inv_tb = 1'b1;
    @(negedge clk);
    inv_tb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog: actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lat, f0;

    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R13 reset ready", 32'(req_ready), 32'd0);
    chk("R13 reset arr_req", 32'(arr_req), 32'd0);

    // replacement order walk
    clear_bufs();
    for (int i = 0; i < NVEC; i++) begin
      logic [15:0] a;
      a = VEC[i][16:1];
      f0 = fetch_cnt;
      do_read(a, 2'd0, d, lat);
      chk(VEC[i][0] ? "R1 hit data" : "R2 miss data", d, mk_word(a[15:3], int'(a[2:0])));
      chk("R3 replacement latency", 32'(lat), VEC[i][0] ? 32'd1 : 32'(MISS_LAT));
      chk("R1 fetch count", 32'(fetch_cnt - f0), VEC[i][0] ? 32'd0 : 32'd1);
    end

    // R4 buffering off
    buf_en = 1'b0; idle(2);
    f0 = fetch_cnt;
    do_read(16'h1000, 2'd0, d, lat);
    do_read(16'h1001, 2'd0, d, lat);
    chk("R4 no hit when off", 32'(lat), 32'(MISS_LAT));
    chk("R4 data when off", d, mk_word(13'h200, 1));
    chk("R4 fetches when off", 32'(fetch_cnt - f0), 32'd2);
    buf_en = 1'b1; idle(2);

    // R5 buf_en toggle clears
    clear_bufs();
    do_read(16'h1100, 2'd0, d, lat);
    do_read(16'h1101, 2'd0, d, lat);
    chk("R5 hit before toggle", 32'(lat), 32'd1);
    buf_en = 1'b0; idle(2); buf_en = 1'b1; idle(2);
    do_read(16'h1102, 2'd0, d, lat);
    chk("R5 miss after toggle", 32'(lat), 32'(MISS_LAT));

    // R6 program/erase start clears
    clear_bufs();
    do_read(16'h1200, 2'd0, d, lat);
    pe_start = 1'b1; @(negedge clk); pe_start = 1'b0; @(negedge clk);
    do_read(16'h1201, 2'd0, d, lat);
    chk("R6 miss after pe_start", 32'(lat), 32'(MISS_LAT));

    // R7 explicit clear
    clear_bufs();
    do_read(16'h1280, 2'd0, d, lat);
    do_read(16'h1281, 2'd0, d, lat);
    chk("R7 hit before clear", 32'(lat), 32'd1);
    clear_bufs();
    do_read(16'h1282, 2'd0, d, lat);
    chk("R7 miss after clear", 32'(lat), 32'(MISS_LAT));

    // R8 clear coinciding with fill
    clear_bufs();
    inv_at_ack = 1'b1;
    do_read(16'h1305, 2'd0, d, lat);
    chk("R8 data still returned", d, mk_word(13'h260, 5));
    do_read(16'h1301, 2'd0, d, lat);
    chk("R8 line discarded", 32'(lat), 32'(MISS_LAT));

    // R9 prefetch enabled for master 1, line wraps to zero
    clear_bufs();
    pf_mask = 4'b0010;
    f0 = fetch_cnt;
    do_read(16'hFFF8, 2'd1, d, lat);
    idle(12);
    chk("R9 demand plus prefetch", 32'(fetch_cnt - f0), 32'd2);
    do_read(16'h0002, 2'd1, d, lat);
    chk("R9 prefetched hit", 32'(lat), 32'd1);
    chk("R9 prefetched data", d, mk_word(13'h0, 2));
    clear_bufs();
    do_read(16'h2000, 2'd2, d, lat);
    idle(12);
    do_read(16'h2008, 2'd2, d, lat);
    chk("R9 masked master no prefetch", 32'(lat), 32'(MISS_LAT));

    // R10 demand before prefetch issue drops it
    clear_bufs();
    do_read(16'h3000, 2'd1, d, lat);
    do_read(16'h3800, 2'd1, d, lat);
    idle(12);
    do_read(16'h3008, 2'd3, d, lat);
    chk("R10 dropped prefetch", 32'(lat), 32'(MISS_LAT));
    pf_mask = '0;

    // R11 emulated wait states
    clear_bufs();
    ews_cnt = 4'd3;
    do_read(16'h4003, 2'd0, d, lat);
    chk("R11 three extra cycles", 32'(lat), 32'(MISS_LAT + 3));
    chk("R11 data", d, mk_word(13'h800, 3));
    ews_cnt = 4'd1;
    do_read(16'h4100, 2'd0, d, lat);
    chk("R11 one extra cycle", 32'(lat), 32'(MISS_LAT + 1));
    ews_cnt = '0;

    // R12 hits ignored and no prefetch under wait states
    clear_bufs();
    do_read(16'h5000, 2'd0, d, lat);
    do_read(16'h5001, 2'd0, d, lat);
    chk("R12 hit at zero waits", 32'(lat), 32'd1);
    ews_cnt = 4'd2;
    f0 = fetch_cnt;
    do_read(16'h5002, 2'd0, d, lat);
    chk("R12 hit ignored latency", 32'(lat), 32'(MISS_LAT + 2));
    chk("R12 hit ignored fetch", 32'(fetch_cnt - f0), 32'd1);
    pf_mask = 4'b0010;
    do_read(16'h5800, 2'd1, d, lat);
    idle(12);
    ews_cnt = '0;
    do_read(16'h5808, 2'd1, d, lat);
    chk("R12 no prefetch under waits", 32'(lat), 32'(MISS_LAT));
    pf_mask = '0;

    chk("R13 ready single cycle", 32'(pulse_bad), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule